// File: doc/BRIEF.md
# Serial Command Receiver

This block takes single-byte commands from a host over a three-wire synchronous link: an active-low select, a serial clock and a data line. All three pins are brought into the local clock domain through synchronizer stages. Rising clock edges are found in that domain by comparing against the previous sampled level. The clock's resting level and the bit order are fixed per instance by two parameters.

While the link is selected and no byte has yet been taken, the ready output is high and each rising clock edge shifts in one data bit. The eighth rising edge completes the byte, which is decoded in the same step. The result appears as a one-cycle pulse on either the event-valid output or the invalid-code output. Event-valid carries a kind code and the phrase field. Once a byte is taken, ready stays low until the host deselects.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, with select high, ready, event-valid and invalid-code are all low.
- R2: Ready is high only while select is low and the current selection has not yet completed a byte; it falls within 3 cycles of select rising.
- R3: Data is taken on rising serial-clock edges only; with LSB_FIRST=0 the first bit taken is bit 7 of the code.
- R4: With LSB_FIRST=1 the first bit taken is bit 0 of the code.
- R5: The edge detector is preset to the IDLE_HIGH level while deselected, so a clock resting at that level when select falls adds no bit.
- R6: The byte completes on exactly the eighth rising edge. A single result pulse follows within 3 cycles of that edge at the pin.
- R7: Code 0x00 gives an event of kind 0 (stop).
- R8: Code 0x01 gives an event of kind 1 (diagnostic).
- R9: Codes 0x02 to 0x3F give an event of kind 2 (play), with the phrase output equal to code bits 5:0.
- R10: A code with bit 7 or bit 6 set pulses the invalid-code output and produces no event-valid pulse.
- R11: Raising select before eight bits arrive discards the partial byte; the next selection starts from bit one.
- R12: After a byte completes, further clock edges in the same selection are ignored and ready stays low.
- R13: Clock edges while select is high shift nothing in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from host |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| ready | output | 1 | High while serial clocks are accepted |
| evt_valid | output | 1 | One-cycle pulse marking a decoded event |
| evt_kind | output | 2 | 0 stop, 1 diagnostic, 2 play |
| evt_phrase | output | 6 | Low six bits of the code |
| evt_bad | output | 1 | One-cycle pulse for a code with a top bit set |

## Verification
A pin change reaches the edge detector after two synchronizer cycles. The result register then loads on the next clock, so a result pulse is due in the third cycle after the eighth rising edge. Ready settles within three cycles of a select change.

The bench holds every level for at least four cycles. It samples only on falling clock edges, where it counts the pulses and records their fields. Each check is made eight cycles after the stimulus, so an early, late or repeated pulse shows up as a wrong count, not as a timing race.

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
  parameter bit IDLE_HIGH  = 1'b1,
  parameter bit LSB_FIRST  = 1'b0,
  parameter int SYNC_DEPTH = 2,
  parameter int CODE_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  output logic                ready,
  output logic                evt_valid,
  output logic [1:0]          evt_kind,
  output logic [CODE_W-3:0]   evt_phrase,
  output logic                evt_bad
);
  localparam int PHR_W = CODE_W - 2;
  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic [SYNC_DEPTH-1:0] cs_sy, sck_sy, sd_sy;
  logic                  sck_prev, done_q;
  logic [CNT_W-1:0]      cnt;
  logic [CODE_W-1:0]     shreg, nxt;

  wire sel  = ~cs_sy[SYNC_DEPTH-1];
  wire sckl = sck_sy[SYNC_DEPTH-1];
  wire bitv = sd_sy[SYNC_DEPTH-1];
  wire rise = sel & ~done_q & sckl & ~sck_prev;
  wire last = rise & (cnt == LAST);

  assign ready = sel & ~done_q;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign nxt = {bitv, shreg[CODE_W-1:1]};
    end else begin : g_msb
      assign nxt = {shreg[CODE_W-2:0], bitv};
    end
  endgenerate

  wire top_set = |nxt[CODE_W-1:CODE_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= '1;
      sck_sy <= {SYNC_DEPTH{IDLE_HIGH}};
      sd_sy  <= '0;
    end else begin
      cs_sy  <= {cs_sy[SYNC_DEPTH-2:0], cs_n};
      sck_sy <= {sck_sy[SYNC_DEPTH-2:0], sck};
      sd_sy  <= {sd_sy[SYNC_DEPTH-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= IDLE_HIGH;
      cnt      <= '0;
      shreg    <= '0;
      done_q   <= 1'b0;
    end else if (!sel) begin
      sck_prev <= IDLE_HIGH;
      cnt      <= '0;
      done_q   <= 1'b0;
    end else begin
      sck_prev <= sckl;
      if (rise) begin
        shreg <= nxt;
        cnt   <= last ? '0 : cnt + 1'b1;
        if (last) done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid  <= 1'b0;
      evt_bad    <= 1'b0;
      evt_kind   <= 2'd0;
      evt_phrase <= '0;
    end else begin
      evt_valid <= last & ~top_set;
      evt_bad   <= last & top_set;
      if (last) begin
        evt_phrase <= nxt[PHR_W-1:0];
        evt_kind   <= (nxt[PHR_W-1:1] != '0) ? 2'd2 : {1'b0, nxt[0]};
      end
    end
  end

  // R10
  valid_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && evt_bad));
  // R9
  play_phrase_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'd2) |-> (evt_phrase >= 2));
  // R12
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid || evt_bad) |-> !ready);
  // R11
  deselect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0));
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid || evt_bad) |=> !(evt_valid || evt_bad));
endmodule

// File: tb/serial_cmd_rx_bench.sv
module serial_cmd_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_a = 1'b1, sck_a = 1'b1, sd_a = 1'b0;
  logic cs_b = 1'b1, sck_b = 1'b0, sd_b = 1'b0;
  logic rdy_a, v_a, bad_a, rdy_b, v_b, bad_b;
  logic [1:0] k_a, k_b;
  logic [5:0] p_a, p_b;
  int n_chk = 0, n_bad = 0, cyc = 0;
  int nv_a = 0, nb_a = 0, nv_b = 0, nb_b = 0;
  logic [1:0] lk_a, lk_b;
  logic [5:0] lp_a, lp_b;

  always #2 clk = ~clk;

  serial_cmd_rx u_serial_cmd_rx (.clk(clk), .rst_n(rst_n), .cs_n(cs_a), .sck(sck_a),
    .sdi(sd_a), .ready(rdy_a), .evt_valid(v_a), .evt_kind(k_a), .evt_phrase(p_a),
    .evt_bad(bad_a));
  serial_cmd_rx #(.IDLE_HIGH(1'b0), .LSB_FIRST(1'b1)) u_serial_cmd_rx_lsb (.clk(clk),
    .rst_n(rst_n), .cs_n(cs_b), .sck(sck_b), .sdi(sd_b), .ready(rdy_b),
    .evt_valid(v_b), .evt_kind(k_b), .evt_phrase(p_b), .evt_bad(bad_b));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (v_a) begin nv_a <= nv_a + 1; lk_a <= k_a; lp_a <= p_a; end
    if (bad_a) nb_a <= nb_a + 1;
    if (v_b) begin nv_b <= nv_b + 1; lk_b <= k_b; lp_b <= p_b; end
    if (bad_b) nb_b <= nb_b + 1;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    waitc(1);
    nv_a = 0; nb_a = 0; nv_b = 0; nb_b = 0;
  endtask

  task automatic sel_a(input bit s);
    cs_a = ~s; waitc(6);
  endtask

  task automatic bits_a(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck_a = 1'b0; sd_a = v[i]; waitc(4);
      sck_a = 1'b1; waitc(4);
    end
    waitc(8);
  endtask

  task automatic cmd_a(input logic [7:0] v);
    sel_a(1); clr(); bits_a(v, 8);
  endtask

  task automatic t_reset();
    check(rdy_a == 0 && v_a == 0 && bad_a == 0, "R1", rdy_a, 0);
    check(rdy_b == 0 && v_b == 0 && bad_b == 0, "R1", rdy_b, 0);
  endtask

  task automatic t_stop();
    sel_a(1);
    check(rdy_a == 1, "R2", rdy_a, 1);
    clr(); bits_a(8'h00, 8);
    check(nv_a == 1 && nb_a == 0, "R6", nv_a, 1);
    check(lk_a == 2'd0, "R7", lk_a, 0);
    check(rdy_a == 0, "R12", rdy_a, 0);
    bits_a(8'h05, 8);
    check(nv_a == 1 && nb_a == 0 && rdy_a == 0, "R12", nv_a, 1);
    sel_a(0);
    check(rdy_a == 0, "R2", rdy_a, 0);
  endtask

  task automatic t_diag();
    cmd_a(8'h01);
    check(nv_a == 1 && lk_a == 2'd1, "R8", lk_a, 1);
    sel_a(0);
  endtask

  task automatic t_play(input logic [7:0] v);
    cmd_a(v);
    check(nv_a == 1 && lk_a == 2'd2, "R9", lk_a, 2);
    check(lp_a == v[5:0], "R3 R5 R9", lp_a, v[5:0]);
    sel_a(0);
  endtask

  task automatic t_bad(input logic [7:0] v);
    cmd_a(v);
    check(nb_a == 1 && nv_a == 0, "R10", nb_a * 10 + nv_a, 10);
    sel_a(0);
  endtask

  task automatic t_abort();
    sel_a(1); clr(); bits_a(8'hFF, 5);
    sel_a(0);
    check(nv_a == 0 && nb_a == 0, "R11", nv_a + nb_a, 0);
    cmd_a(8'h05);
    check(nv_a == 1 && lp_a == 6'h05, "R11", lp_a, 5);
    sel_a(0);
  endtask

  task automatic t_desel_clocks();
    clr(); bits_a(8'hFF, 8);
    check(nv_a == 0 && nb_a == 0, "R13", nv_a + nb_a, 0);
    cmd_a(8'h03);
    check(nv_a == 1 && lp_a == 6'h03, "R13", lp_a, 3);
    sel_a(0);
  endtask

  task automatic t_lsb(input logic [7:0] v);
    cs_b = 1'b0; waitc(6); clr();
    for (int i = 0; i < 8; i++) begin
      sd_b = v[i]; waitc(4);
      sck_b = 1'b1; waitc(4);
      sck_b = 1'b0;
    end
    waitc(8);
    check(nv_b == 1 && lk_b == 2'd2, "R4", lk_b, 2);
    check(lp_b == v[5:0], "R4 R5", lp_b, v[5:0]);
    cs_b = 1'b1; waitc(6);
  endtask

  always @(negedge clk) if (cyc > 100000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    waitc(3); rst_n = 1'b1; waitc(4);
    t_reset();
    t_stop();
    t_diag();
    t_play(8'h2D);
    t_play(8'h02);
    t_play(8'h3F);
    t_bad(8'h80);
    t_bad(8'h41);
    t_abort();
    t_desel_clocks();
    t_lsb(8'h2D);
    t_lsb(8'h13);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule